// File: doc/BRIEF.md
# Memory Access Fault Checker

This block screens every load, store and instruction fetch before it goes to memory. Each request comes with an address, a size code, an access kind and a core-flavour select. One cycle later the block returns an address forced to the natural alignment of the size, together with a vector of fault flags. A downstream exception unit decides what to do with those flags.

Two core flavours are supported, and each has its own rules.

- Flavour A reports misalignment as a data access error. That error can be masked. Flavour A also guards one upper window for doubleword data and for instruction fetches.
- Flavour B raises a separate not-aligned fault. It guards a set of error windows, and it treats the lower peripheral window as an exception region. For fetches it applies a fixed priority among its windows. Fetches into a small boot area fault only while boot memory is disabled.
- Any other flavour code passes the address through with no checks.

Top module: `mem_fault_chk`

## Requirements
- R1: The alignment mask follows the size code: 0=byte mask 0, 1=half mask 1, 2=word mask 3, 3=double mask 7, 4=quad mask 15. For instruction fetches the mask is always 3. When the flavour is A (variant code 0) or B (variant code 1), out_addr equals the input address with the mask bits cleared.
- R2: Fault vector bit positions are: [0] not-aligned, [1] data access error, [2] data access exception, [3] instruction access error, [4] instruction access exception, [5] data store error. Results appear exactly one cycle after a valid request, qualified by out_valid. With no request, out_valid is 0.
- R3: Flavour A, data read or write, misaligned: bit1 is set unless mask_misalign is 1. Bit0 is never set on flavour A.
- R4: Flavour A, double or quad data read with the aligned address in 0xFE800000..0xFEFFFFFF sets bit1. A double or quad write in that window sets bit5. Smaller sizes in that window raise nothing.
- R5: Flavour A fetch: misalignment sets bit3. Otherwise, an address in 0xFE800000..0xFEFFFFFF sets bit3.
- R6: Flavour B: any misaligned read, write or fetch sets bit0. The range checks then use the aligned address.
- R7: Flavour B data: a read in 0xFEFF0600..0xFEFF7FFF or 0xFE800000..0xFEFEFFFF sets bit1. A write in those windows sets bit5.
- R8: Flavour B data: a read or write in 0xFE000000..0xFE7FFFFF sets bit2.
- R9: Flavour B fetch priority: the error windows of R7 set bit3 only. Otherwise 0xFE004000..0xFE7FFFFF sets bit4. Otherwise 0xFE000000..0xFE003FFF sets bit4 only when boot_en is 0.
- R10: A variant code other than 0 or 1 gives no faults, and the address passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low async reset |
| in_valid | input | 1 | request strobe |
| in_addr | input | 32 | request address |
| in_size | input | 3 | size code (R1) |
| in_kind | input | 2 | 0 read, 1 write, 2 fetch |
| in_variant | input | 2 | 0 flavour A, 1 flavour B |
| mask_misalign | input | 1 | suppresses flavour A misalign error |
| boot_en | input | 1 | boot memory enabled |
| out_valid | output | 1 | result valid |
| out_addr | output | 32 | corrected address |
| out_fault | output | 6 | fault flags (R2) |

## Verification
Every result is due exactly one clock edge after the edge that captures its request, because a single register stage sits between the inputs and the outputs. The driver pushes each expected address and fault vector into a queue when it presents the request. The monitor samples out_valid on the falling edge that follows the next rising edge, so requests issued back-to-back are compared in order without any gap. Idle cycles check that out_valid stays low.

// File: rtl/mem_fault_chk_pkg.sv
package mem_fault_chk_pkg;
    localparam int ADDR_W  = 32;
    localparam int FAULT_W = 6;

    localparam int F_UNALIGN  = 0;
    localparam int F_DERR     = 1;
    localparam int F_DEXC     = 2;
    localparam int F_IERR     = 3;
    localparam int F_IEXC     = 4;
    localparam int F_STOREERR = 5;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_FETCH = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        V_A = 2'd0,
        V_B = 2'd1
    } variant_e;

    typedef struct packed {
        logic               valid;
        logic [ADDR_W-1:0]  addr;
        logic [FAULT_W-1:0] fault;
    } result_t;

    function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] lo,
                                    input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction
endpackage

// File: rtl/mfc_align.sv
module mfc_align
    import mem_fault_chk_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic [2:0]    size,
    input  logic          fetch,
    output logic [AW-1:0] aligned,
    output logic          misaligned
);
    logic [3:0] mask;

    always_comb begin
        if (fetch) begin
            mask = 4'h3;
        end else begin
            case (size)
                3'd0:    mask = 4'h0;
                3'd1:    mask = 4'h1;
                3'd2:    mask = 4'h3;
                3'd3:    mask = 4'h7;
                3'd4:    mask = 4'hF;
                default: mask = 4'h0;
            endcase
        end
        misaligned = |(addr[3:0] & mask);
        aligned    = {addr[AW-1:4], addr[3:0] & ~mask};
    end
endmodule

// File: rtl/mfc_rules_a.sv
module mfc_rules_a
    import mem_fault_chk_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic               misaligned,
    input  logic [1:0]         kind,
    input  logic               wide,
    input  logic               mask_misalign,
    output logic [FAULT_W-1:0] fault
);
    logic upper;

    always_comb begin
        fault = '0;
        upper = in_win(addr, 32'hFE80_0000, 32'hFEFF_FFFF);
        case (kind)
            K_READ, K_WRITE: begin
                if (misaligned && !mask_misalign) fault[F_DERR] = 1'b1;
                if (wide && upper) begin
                    if (kind == K_READ) fault[F_DERR]     = 1'b1;
                    else                fault[F_STOREERR] = 1'b1;
                end
            end
            K_FETCH: begin
                if (misaligned) fault[F_IERR] = 1'b1;
                else if (upper) fault[F_IERR] = 1'b1;
            end
            default: fault = '0;
        endcase
    end
endmodule

// File: rtl/mfc_rules_b.sv
module mfc_rules_b
    import mem_fault_chk_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic               misaligned,
    input  logic [1:0]         kind,
    input  logic               boot_en,
    output logic [FAULT_W-1:0] fault
);
    logic err_win, exc_all, exc_hi, boot_win;

    always_comb begin
        fault    = '0;
        err_win  = in_win(addr, 32'hFEFF_0600, 32'hFEFF_7FFF) ||
                   in_win(addr, 32'hFE80_0000, 32'hFEFE_FFFF);
        exc_all  = in_win(addr, 32'hFE00_0000, 32'hFE7F_FFFF);
        exc_hi   = in_win(addr, 32'hFE00_4000, 32'hFE7F_FFFF);
        boot_win = in_win(addr, 32'hFE00_0000, 32'hFE00_3FFF);
        fault[F_UNALIGN] = misaligned && (kind != 2'd3);
        case (kind)
            K_READ: begin
                fault[F_DERR] = err_win;
                fault[F_DEXC] = exc_all;
            end
            K_WRITE: begin
                fault[F_STOREERR] = err_win;
                fault[F_DEXC]     = exc_all;
            end
            K_FETCH: begin
                if (err_win)                  fault[F_IERR] = 1'b1;
                else if (exc_hi)              fault[F_IEXC] = 1'b1;
                else if (boot_win && !boot_en) fault[F_IEXC] = 1'b1;
            end
            default: fault = '0;
        endcase
    end
endmodule

// File: rtl/mem_fault_chk.sv
module mem_fault_chk
    import mem_fault_chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_addr,
    input  logic [2:0]  in_size,
    input  logic [1:0]  in_kind,
    input  logic [1:0]  in_variant,
    input  logic        mask_misalign,
    input  logic        boot_en,
    output logic        out_valid,
    output logic [31:0] out_addr,
    output logic [5:0]  out_fault
);
    logic [ADDR_W-1:0]  aligned;
    logic               misaligned;
    logic [FAULT_W-1:0] fault_a, fault_b;
    logic               fetch;
    result_t            res_d, res_q;

    assign fetch = (in_kind == K_FETCH);

    mfc_align #(.AW(ADDR_W)) u_align (
        .addr(in_addr), .size(in_size), .fetch(fetch),
        .aligned(aligned), .misaligned(misaligned)
    );

    mfc_rules_a u_ra (
        .addr(aligned), .misaligned(misaligned), .kind(in_kind),
        .wide(in_size == 3'd3 || in_size == 3'd4),
        .mask_misalign(mask_misalign), .fault(fault_a)
    );

    mfc_rules_b u_rb (
        .addr(aligned), .misaligned(misaligned), .kind(in_kind),
        .boot_en(boot_en), .fault(fault_b)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            case (in_variant)
                V_A: begin
                    res_d.addr  = aligned;
                    res_d.fault = fault_a;
                end
                V_B: begin
                    res_d.addr  = aligned;
                    res_d.fault = fault_b;
                end
                default: begin
                    res_d.addr  = in_addr;
                    res_d.fault = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_addr  = res_q.addr;
    assign out_fault = res_q.fault;

    // R2: one-cycle latency of the valid qualifier
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3: flavour A never reports not-aligned
    p_a_noalign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_variant == V_A) |=> !out_fault[F_UNALIGN]);
    // R10: unknown flavour passes address untouched with no faults
    p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_variant[1]) |=> (out_fault == '0 && out_addr == $past(in_addr)));
    // R9: fetch raises at most one of error/exception
    p_fetch_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == K_FETCH) |=> !(out_fault[F_IERR] && out_fault[F_IEXC]));
    // R1: flavour B fetch result is word aligned
    p_fetch_al_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == K_FETCH && in_variant == V_B) |=> (out_addr[1:0] == 2'b00));
endmodule

// File: tb/mem_fault_chk_bench.sv
module mem_fault_chk_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic [2:0]  in_size = '0;
    logic [1:0]  in_kind = '0;
    logic [1:0]  in_variant = '0;
    logic        mask_misalign = 1'b0;
    logic        boot_en = 1'b0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [5:0]  out_fault;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] addr;
        logic [5:0]  fault;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    mem_fault_chk u_mem_fault_chk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_size(in_size), .in_kind(in_kind), .in_variant(in_variant),
        .mask_misalign(mask_misalign), .boot_en(boot_en),
        .out_valid(out_valid), .out_addr(out_addr), .out_fault(out_fault)
    );

    task automatic send(input logic [1:0] v, input logic [1:0] k, input logic [2:0] s,
                        input logic [31:0] a, input logic mm, input logic be,
                        input logic [31:0] ea, input logic [5:0] ef, input string tag);
        in_valid = 1'b1; in_variant = v; in_kind = k; in_size = s;
        in_addr = a; mask_misalign = mm; boot_en = be;
        q.push_back('{ea, ef, tag});
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                total++;
                if (q.size() == 0) begin
                    bad++;
                    $display("FAIL R2 unexpected out_valid addr=%h", out_addr);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (out_addr !== e.addr || out_fault !== e.fault) begin
                        bad++;
                        $display("FAIL %s got addr=%h fault=%b exp addr=%h fault=%b",
                                 e.tag, out_addr, out_fault, e.addr, e.fault);
                    end
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #3;
        total++;
        if (out_valid !== 1'b0 || out_fault !== '0) begin
            bad++;
            $display("FAIL R2 reset valid=%b fault=%b exp 0", out_valid, out_fault);
        end
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 alignment for each size, flavour B clean region
        send(1, 0, 0, 32'h1000_0003, 0, 1, 32'h1000_0003, 6'b000000, "R1 byte");
        send(1, 0, 1, 32'h1000_0002, 0, 1, 32'h1000_0002, 6'b000000, "R1 half ok");
        send(1, 0, 2, 32'h1000_0006, 0, 1, 32'h1000_0004, 6'b000001, "R6 word mis");
        send(1, 1, 3, 32'h1000_000C, 0, 1, 32'h1000_0008, 6'b000001, "R6 dbl mis");
        send(1, 1, 4, 32'h1000_0018, 0, 1, 32'h1000_0010, 6'b000001, "R1 quad mis");
        send(1, 2, 0, 32'h1000_0002, 0, 1, 32'h1000_0000, 6'b000001, "R6 fetch mis");
        // R3 flavour A misalign
        send(0, 0, 2, 32'h2000_0001, 0, 1, 32'h2000_0000, 6'b000010, "R3 A mis read");
        send(0, 1, 1, 32'h2000_0001, 1, 1, 32'h2000_0000, 6'b000000, "R3 A masked");
        // R4
        send(0, 0, 3, 32'hFE90_0000, 0, 1, 32'hFE90_0000, 6'b000010, "R4 A dbl read");
        send(0, 1, 4, 32'hFEFF_FFF0, 0, 1, 32'hFEFF_FFF0, 6'b100000, "R4 A quad write");
        send(0, 0, 2, 32'hFE90_0000, 0, 1, 32'hFE90_0000, 6'b000000, "R4 A word none");
        // R5
        send(0, 2, 2, 32'hFE80_0000, 0, 1, 32'hFE80_0000, 6'b001000, "R5 A fetch win");
        send(0, 2, 2, 32'h3000_0002, 0, 1, 32'h3000_0000, 6'b001000, "R5 A fetch mis");
        // R7, R8
        send(1, 0, 2, 32'hFEFF_0600, 0, 1, 32'hFEFF_0600, 6'b000010, "R7 B read err");
        send(1, 1, 2, 32'hFE80_0000, 0, 1, 32'hFE80_0000, 6'b100000, "R7 B write err");
        send(1, 0, 2, 32'hFEFF_8000, 0, 1, 32'hFEFF_8000, 6'b000000, "R7 B gap");
        send(1, 1, 0, 32'hFE7F_FFFF, 0, 1, 32'hFE7F_FFFF, 6'b000100, "R8 B write exc");
        send(1, 0, 2, 32'hFE00_0000, 0, 0, 32'hFE00_0000, 6'b000100, "R8 B read exc");
        // R9
        send(1, 2, 2, 32'hFEFF_7FFC, 0, 0, 32'hFEFF_7FFC, 6'b001000, "R9 B fetch err");
        send(1, 2, 2, 32'hFE00_4000, 0, 1, 32'hFE00_4000, 6'b010000, "R9 B fetch exc");
        send(1, 2, 2, 32'hFE00_3FFC, 0, 0, 32'hFE00_3FFC, 6'b010000, "R9 B boot off");
        send(1, 2, 2, 32'hFE00_3FFC, 0, 1, 32'hFE00_3FFC, 6'b000000, "R9 B boot on");
        // R10
        send(2, 0, 3, 32'hFE90_0003, 0, 0, 32'hFE90_0003, 6'b000000, "R10 pass");
        send(3, 2, 2, 32'hFE00_0001, 0, 0, 32'hFE00_0001, 6'b000000, "R10 pass fetch");
        repeat (3) @(posedge clk);
        #2;
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R2 missing results got=%0d exp=0", q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule